// File: doc/BRIEF.md
# Machine-Check Capture and Clock-Freeze Controller

This block collects parity-error pulses from the processor's checkers into a 32-bit sticky check register. It decides when to stop the processor clock so that the machine state is held for analysis. The checkers fall into two timing classes. An early-class error drops the clock-run enable in the same cycle it is reported, which blocks that cycle's set-register strobe. A late-class error (carry, mover output, full-sum) arrives too late for that. It lets the current strobe through and stops the clock one cycle later.

A backup register captures the microprogram address on every set-register strobe while the clock runs. After a late-class stop it therefore still holds the address of the faulting cycle, so analysis can step back to that cycle. Once the clock is frozen, a small sequencer waits for the external logout transfer to report completion. It then clears the check register, raises a one-cycle machine-check interrupt request and parks until a restart request lets the clock run again.

Top module: `mchk_ctrl`

## Requirements
- R1: A check input in bit positions 0-3, 9-15 or 18-24 that is high while the controller runs drives `clk_run` low in that same cycle, and `clk_run` stays low afterwards.
- R2: A check input in bit positions 4-8 or 16, with no other valid check input, leaves `clk_run` high in its own cycle and drives it low from the next cycle on.
- R3: `uaddr_backup` takes `uaddr` at a clock edge where `set_strobe` and `clk_run` are both high; otherwise it holds its value, so after a late-class stop it shows the faulting cycle's address.
- R4: Each valid check input sets the `check_reg` bit with its own index on the next edge, several inputs in one cycle set all their bits, and set bits stay set until a clear.
- R5: Check inputs in positions 17, 25 and 27-31 have no effect: they neither set a bit nor stop the clock.
- R6: `logout_key` or `chan_logout_req` sets `check_reg` bit 26 on the next edge in any state and never stops the clock.
- R7: `check_reset` or `diag_reset` clears `check_reg` on the next edge (clear wins over a set); `rst` clears the register and the backup, raises `clk_run` and drops `mck_irq`.
- R8: `logout_done` while frozen clears `check_reg` on the next edge, and `mck_irq` is high for exactly that following cycle; `logout_done` while running has no effect.
- R9: After the interrupt the clock stays stopped until `restart`, which raises `clk_run` on the next edge; `restart` before the logout has completed is ignored.
- R10: Check inputs that arrive while the clock is stopped are not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous active-high system reset |
| chk_in | input | 32 | One error line per check-register position |
| uaddr | input | ADDR_W | Microprogram address of the current cycle |
| set_strobe | input | 1 | Per-cycle register-load strobe |
| logout_key | input | 1 | Operator logout request |
| chan_logout_req | input | 1 | Channel error-logout request |
| check_reset | input | 1 | Clears the check register |
| diag_reset | input | 1 | Diagnostic clear of the check register |
| logout_done | input | 1 | External logout transfer finished |
| restart | input | 1 | Let the clock run again after the interrupt |
| clk_run | output | 1 | Clock-run enable for the processor |
| check_reg | output | 32 | Sticky check register |
| uaddr_backup | output | ADDR_W | Address in control during the previous strobed cycle |
| mck_irq | output | 1 | One-cycle machine-check interrupt request |

## Verification
`clk_run` responds to an early-class input combinationally, so the bench reads it in the same cycle, one time step after it drives the input. A late-class input is checked at that point for a still-high enable, and again after the next rising edge for a low one. The check register, the backup address and the sequencer results (register clear, interrupt pulse, restart) each sit one register behind their cause. The bench changes inputs two time steps after an edge and reads these outputs there, a full edge after the stimulus. The interrupt is also read one more edge later to show that it lasted a single cycle.

// File: rtl/mchk_pkg.sv
package mchk_pkg;

    localparam int CHK_W      = 32;
    localparam int LOG_BIT    = 26;

    // Positions driven by a real checker (0-16, 18-24)
    localparam logic [CHK_W-1:0] CHECKER_MASK = 32'h01FD_FFFF;
    // Late-class positions: full-sum bytes 4-7, carry 8, mover output 16
    localparam logic [CHK_W-1:0] LATE_MASK    = 32'h0001_01F0;
    localparam logic [CHK_W-1:0] EARLY_MASK   = CHECKER_MASK & ~LATE_MASK;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_INTR = 2'd2,
        ST_PARK = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic early;
        logic late;
    } err_class_t;

    function automatic err_class_t classify(input logic [CHK_W-1:0] v);
        err_class_t c;
        c.early = |(v & EARLY_MASK);
        c.late  = |(v & LATE_MASK);
        return c;
    endfunction

endpackage

// File: rtl/mchk_seq.sv
module mchk_seq
    import mchk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_class_t cls_i,
    input  logic       logout_done_i,
    input  logic       restart_i,
    output logic       clk_run_o,
    output logic       capture_en_o,
    output logic       clr_req_o,
    output logic       irq_o
);

    seq_state_t state_q, state_d;
    logic       running;

    assign running = (state_q == ST_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (cls_i.early || cls_i.late) state_d = ST_HALT;
            ST_HALT: if (logout_done_i)              state_d = ST_INTR;
            ST_INTR:                                 state_d = ST_PARK;
            ST_PARK: if (restart_i)                  state_d = ST_RUN;
            default:                                 state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    assign clk_run_o    = running && !cls_i.early;
    assign capture_en_o = running;
    assign clr_req_o    = (state_q == ST_HALT) && logout_done_i;
    assign irq_o        = (state_q == ST_INTR);

    assert_halt_holds_R1: assert property (@(posedge clk) disable iff (rst)
        (running && cls_i.early) |=> !clk_run_o);

    assert_late_next_R2: assert property (@(posedge clk) disable iff (rst)
        (running && cls_i.late && !cls_i.early) |=> !clk_run_o);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    assert_irq_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(logout_done_i));

    assert_restart_runs_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PARK && restart_i) |=> running);

endmodule

// File: rtl/mchk_capture.sv
module mchk_capture
    import mchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CHK_W-1:0] chk_i,
    input  logic             capture_en_i,
    input  logic             log_req_i,
    input  logic             clear_i,
    output logic [CHK_W-1:0] reg_o
);

    for (genvar i = 0; i < CHK_W; i++) begin : g_bit
        if (CHECKER_MASK[i]) begin : g_checker
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst || clear_i)                 bit_q <= 1'b0;
                else if (capture_en_i && chk_i[i])  bit_q <= 1'b1;
            end
            assign reg_o[i] = bit_q;
        end else if (i == LOG_BIT) begin : g_log
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst || clear_i)   bit_q <= 1'b0;
                else if (log_req_i)   bit_q <= 1'b1;
            end
            assign reg_o[i] = bit_q;
        end else begin : g_unused
            assign reg_o[i] = 1'b0;
        end
    end

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((reg_o & $past(reg_o)) == $past(reg_o)));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (reg_o == '0));

    assert_log_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (log_req_i && !clear_i) |=> reg_o[LOG_BIT]);

endmodule

// File: rtl/mchk_backup.sv
module mchk_backup #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] uaddr_i,
    input  logic              strobe_i,
    input  logic              clk_run_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)                          addr_q <= '0;
        else if (strobe_i && clk_run_i)   addr_q <= uaddr_i;
    end

    assign addr_o = addr_q;

    assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        !clk_run_i |=> $stable(addr_q));

endmodule

// File: rtl/mchk_ctrl.sv
module mchk_ctrl
    import mchk_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHK_W-1:0]  chk_in,
    input  logic [ADDR_W-1:0] uaddr,
    input  logic              set_strobe,
    input  logic              logout_key,
    input  logic              chan_logout_req,
    input  logic              check_reset,
    input  logic              diag_reset,
    input  logic              logout_done,
    input  logic              restart,
    output logic              clk_run,
    output logic [CHK_W-1:0]  check_reg,
    output logic [ADDR_W-1:0] uaddr_backup,
    output logic              mck_irq
);

    err_class_t cls;
    logic       capture_en;
    logic       seq_clr;
    logic       clear_all;
    logic       run_en;

    assign cls       = classify(chk_in);
    assign clear_all = check_reset || diag_reset || seq_clr;

    mchk_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .cls_i         (cls),
        .logout_done_i (logout_done),
        .restart_i     (restart),
        .clk_run_o     (run_en),
        .capture_en_o  (capture_en),
        .clr_req_o     (seq_clr),
        .irq_o         (mck_irq)
    );

    mchk_capture u_capture (
        .clk          (clk),
        .rst          (rst),
        .chk_i        (chk_in),
        .capture_en_i (capture_en),
        .log_req_i    (logout_key || chan_logout_req),
        .clear_i      (clear_all),
        .reg_o        (check_reg)
    );

    mchk_backup #(.ADDR_W(ADDR_W)) u_backup (
        .clk       (clk),
        .rst       (rst),
        .uaddr_i   (uaddr),
        .strobe_i  (set_strobe),
        .clk_run_i (run_en),
        .addr_o    (uaddr_backup)
    );

    assign clk_run = run_en;

    assert_no_capture_stopped_R10: assert property (@(posedge clk) disable iff (rst)
        (!capture_en && !chk_in[LOG_BIT] && !logout_key && !chan_logout_req && !clear_all)
            |=> $stable(check_reg));

endmodule

// File: tb/tb_mchk_ctrl.sv
module tb_mchk_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [31:0]   chk_in;
    logic [AW-1:0] uaddr;
    logic          set_strobe, logout_key, chan_logout_req;
    logic          check_reset, diag_reset, logout_done, restart;
    logic          clk_run, mck_irq;
    logic [31:0]   check_reg;
    logic [AW-1:0] uaddr_backup;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mchk_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .chk_in(chk_in), .uaddr(uaddr),
        .set_strobe(set_strobe), .logout_key(logout_key),
        .chan_logout_req(chan_logout_req), .check_reset(check_reset),
        .diag_reset(diag_reset), .logout_done(logout_done),
        .restart(restart), .clk_run(clk_run), .check_reg(check_reg),
        .uaddr_backup(uaddr_backup), .mck_irq(mck_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        chk_in = '0; uaddr = '0; set_strobe = 0; logout_key = 0;
        chan_logout_req = 0; check_reset = 0; diag_reset = 0;
        logout_done = 0; restart = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    // Drive a frozen controller through logout, interrupt and restart.
    task automatic recover();
        logout_done = 1;
        #1 chk("R8 irq idle before done edge", {31'd0, mck_irq}, 32'd0);
        tick();
        logout_done = 0;
        chk("R8 register cleared by logout", check_reg, 32'd0);
        chk("R8 irq raised", {31'd0, mck_irq}, 32'd1);
        tick();
        chk("R8 irq one cycle", {31'd0, mck_irq}, 32'd0);
        chk("R9 parked stopped", {31'd0, clk_run}, 32'd0);
        restart = 1;
        tick();
        restart = 0;
        chk("R9 restart runs", {31'd0, clk_run}, 32'd1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R7 reset check_reg", check_reg, 32'd0);
        chk("R7 reset clk_run", {31'd0, clk_run}, 32'd1);
        chk("R7 reset irq", {31'd0, mck_irq}, 32'd0);
        chk("R7 reset backup", {20'd0, uaddr_backup}, 32'd0);
    endtask

    task automatic t_backup_track();
        for (int i = 1; i <= 3; i++) begin
            uaddr = AW'(12'h100 + i); set_strobe = 1;
            tick();
            chk("R3 backup follows strobe", {20'd0, uaddr_backup}, 32'h100 + i);
        end
        uaddr = 12'h2AA; set_strobe = 0;
        tick();
        chk("R3 backup holds without strobe", {20'd0, uaddr_backup}, 32'h103);
    endtask

    task automatic t_early();
        uaddr = 12'h055; set_strobe = 1; chk_in = 32'h0000_1000; // bit 12
        #1 chk("R1 early drops clk_run same cycle", {31'd0, clk_run}, 32'd0);
        tick();
        chk_in = '0; uaddr = 12'h056;
        chk("R3 early error blocks backup load", {20'd0, uaddr_backup}, 32'h103);
        chk("R4 early bit recorded", check_reg, 32'h0000_1000);
        chk("R1 stays stopped", {31'd0, clk_run}, 32'd0);
        chk_in = 32'h0000_0008; // bit 3 while stopped
        tick();
        chk_in = '0;
        chk("R10 stopped input not recorded", check_reg, 32'h0000_1000);
        chk("R3 backup held while frozen", {20'd0, uaddr_backup}, 32'h103);
        restart = 1;
        tick();
        restart = 0;
        chk("R9 restart before logout ignored", {31'd0, clk_run}, 32'd0);
        set_strobe = 0;
        recover();
    endtask

    task automatic t_late();
        uaddr = 12'h3C1; set_strobe = 1; chk_in = 32'h0000_0100; // carry bit 8
        #1 chk("R2 late keeps clk_run in error cycle", {31'd0, clk_run}, 32'd1);
        tick();
        chk_in = '0; uaddr = 12'h3C2;
        #1 chk("R2 late stops next cycle", {31'd0, clk_run}, 32'd0);
        chk("R3 backup has faulting address", {20'd0, uaddr_backup}, 32'h3C1);
        tick();
        chk("R3 backup unchanged after stop", {20'd0, uaddr_backup}, 32'h3C1);
        chk("R4 carry bit recorded", check_reg, 32'h0000_0100);
        set_strobe = 0;
        recover();
        chk_in = 32'h0001_0000; // mover output bit 16
        #1 chk("R2 mover output is late", {31'd0, clk_run}, 32'd1);
        tick();
        chk_in = '0;
        chk("R2 mover output stops next", {31'd0, clk_run}, 32'd0);
        recover();
    endtask

    task automatic t_multi();
        chk_in = 32'h0020_0002; // bits 1 and 21
        tick();
        chk_in = '0;
        chk("R4 two bits at once", check_reg, 32'h0020_0002);
        logout_key = 1;
        tick();
        logout_key = 0;
        chk("R6 log bit set while frozen, others sticky", check_reg, 32'h0420_0002);
        check_reset = 1;
        tick();
        check_reset = 0;
        chk("R7 check_reset clears", check_reg, 32'd0);
        chk("R7 clear keeps freeze", {31'd0, clk_run}, 32'd0);
        recover();
    endtask

    task automatic t_ignored();
        chk_in = 32'hFA02_0000; // bits 17, 25, 27-31
        #1 chk("R5 reserved inputs keep clk_run", {31'd0, clk_run}, 32'd1);
        tick();
        chk_in = '0;
        chk("R5 reserved inputs set nothing", check_reg, 32'd0);
        chk("R5 still running", {31'd0, clk_run}, 32'd1);
    endtask

    task automatic t_logreq();
        chan_logout_req = 1;
        #1 chk("R6 channel request keeps clk_run", {31'd0, clk_run}, 32'd1);
        tick();
        chan_logout_req = 0;
        chk("R6 channel request sets bit 26", check_reg, 32'h0400_0000);
        logout_done = 1;
        tick();
        logout_done = 0;
        chk("R8 done while running no irq", {31'd0, mck_irq}, 32'd0);
        chk("R8 done while running keeps reg", check_reg, 32'h0400_0000);
        diag_reset = 1; logout_key = 1;
        tick();
        diag_reset = 0; logout_key = 0;
        chk("R7 diag clear wins over set", check_reg, 32'd0);
        chk("R6 log request never stops", {31'd0, clk_run}, 32'd1);
    endtask

    task automatic t_sysreset_frozen();
        uaddr = 12'h0F0; set_strobe = 1;
        tick();
        chk_in = 32'h0004_0000; // bit 18
        tick();
        chk_in = '0; set_strobe = 0;
        chk("R1 storage address bit stops", {31'd0, clk_run}, 32'd0);
        rst = 1;
        tick();
        rst = 0;
        chk("R7 system reset clears reg", check_reg, 32'd0);
        chk("R7 system reset runs clock", {31'd0, clk_run}, 32'd1);
        chk("R7 system reset clears backup", {20'd0, uaddr_backup}, 32'd0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_backup_track();
        t_early();
        t_late();
        t_multi();
        t_ignored();
        t_logreq();
        t_sysreset_frozen();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule